// File: doc/BRIEF.md
# Funnel Shifter with Four Shift Modes

This block shifts or rotates a data word by a run-time amount in a single combinational pass. At its centre is one right-extracting funnel. The funnel joins an upper word and a lower word into a double-width value and returns the word-wide window that starts at a chosen bit offset.

A small mode decoder chooses the upper word, the lower word and the offset. With those three choices the same funnel performs:

- logical right shift,
- arithmetic right shift,
- rotate right,
- logical left shift.

The window is selected by a cascade of 2:1 multiplexer stages. Each stage moves the value by zero or by one power of two, under control of one bit of the offset.

The block has no clock and no storage. A surrounding datapath applies a word, an amount and a mode, and reads the result in the same cycle.

Top module: `funnel_shifter`

## Requirements
- R1: With mode 2'b00 (logical right), `dout` equals `din` shifted right by `amt`, and the vacated top `amt` bits are zero.
- R2: With mode 2'b01 (arithmetic right), `dout` equals `din` shifted right by `amt`, and the vacated top `amt` bits are copies of `din[31]`.
- R3: With mode 2'b10 (rotate right), bit j of `dout` equals bit (j+`amt`) mod 32 of `din`, so the number of ones in `dout` equals the number of ones in `din`.
- R4: With mode 2'b11 (logical left), `dout` equals `din` shifted left by `amt`, and the low `amt` bits are zero.
- R5: When `amt` is 0, `dout` equals `din` in every mode, including logical left.
- R6: The block is purely combinational: `dout` follows the current `din`, `amt` and `mode` with no clock and no state, and gives 0 for `din` equal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din  | input  | 32 | Data word to shift or rotate |
| amt  | input  | 5  | Shift or rotate amount, 0 to 31 |
| mode | input  | 2  | 00 logical right, 01 arithmetic right, 10 rotate right, 11 logical left |
| dout | output | 32 | Shifted or rotated result |

## Verification
The bench uses the default word width of 32, so the amount input is 5 bits wide. It applies all 32 amounts in each of the four modes, which reaches every combination of the five multiplexer stages. It also reaches the left-shift amount of zero, whose offset wraps and needs the special pass-through path.

The data patterns are a lone sign bit, all ones, a lone low bit, the largest positive word, a fixed mixed word and several random words. Together they exercise both sign-fill values and expose any bit of the upper or lower word that lands in the wrong place.

// File: rtl/funnel_pkg.sv
package funnel_pkg;

  // Mode code; the numeric values are part of the port contract
  typedef enum logic [1:0] {
    SH_LRIGHT = 2'b00,
    SH_ARIGHT = 2'b01,
    SH_ROTR   = 2'b10,
    SH_LLEFT  = 2'b11
  } shmode_e;

endpackage

// File: rtl/funnel_ctrl.sv
module funnel_ctrl
  import funnel_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  shmode_e       mode,
  output logic [W-2:0]  upper,   // top bit of the upper word never reaches the window
  output logic [W-1:0]  lower,
  output logic [AW-1:0] offs
);

  // Left shift by a becomes a right extraction at W-a; a=0 wraps to 0
  function automatic logic [AW-1:0] left_offset(input logic [AW-1:0] a);
    return AW'(W - int'(a));
  endfunction

  always_comb begin
    upper = '0;
    lower = din;
    offs  = amt;
    unique case (mode)
      SH_LRIGHT: begin
        upper = '0;
        lower = din;
      end
      SH_ARIGHT: begin
        upper = {(W-1){din[W-1]}};
        lower = din;
      end
      SH_ROTR: begin
        upper = din[W-2:0];
        lower = din;
      end
      SH_LLEFT: begin
        upper = din[W-2:0];
        // zero amount: offset wraps to 0, so pass din through the lower word
        lower = (amt == '0) ? din : '0;
        offs  = left_offset(amt);
      end
      default: begin
        upper = '0;
        lower = din;
      end
    endcase
  end

endmodule

// File: rtl/funnel_stage.sv
module funnel_stage #(
  parameter int IW   = 63,
  parameter int STEP = 1,
  parameter int OW   = IW - STEP
) (
  input  logic [IW-1:0] vin,
  input  logic          sel,
  output logic [OW-1:0] vout
);

  // Move right by STEP or by nothing; the window narrows by STEP each stage
  always_comb vout = sel ? vin[STEP +: OW] : vin[0 +: OW];

endmodule

// File: rtl/funnel_core.sv
module funnel_core #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-2:0]  upper,
  input  logic [W-1:0]  lower,
  input  logic [AW-1:0] offs,
  output logic [W-1:0]  win
);

  localparam int CW = 2*W - 1;   // usable width of the concatenation

  logic [CW-1:0] cat;
  assign cat = {upper, lower};

  for (genvar k = 0; k < AW; k++) begin : g_st
    localparam int IW = 2*W - (1 << k);
    localparam int OW = IW - (1 << k);
    logic [IW-1:0] cur;
    logic [OW-1:0] nxt;
    if (k == 0) begin : g_first
      assign cur = cat;
    end else begin : g_next
      assign cur = g_st[k-1].nxt;
    end
    funnel_stage #(.IW(IW), .STEP(1 << k), .OW(OW)) u_stage (
      .vin  (cur),
      .sel  (offs[k]),
      .vout (nxt)
    );
  end

  assign win = g_st[AW-1].nxt;

  always_comb begin
    if (offs == '0) begin
      p_offset_zero_r5: assert (win == lower)
        else $error("zero offset must return the lower word");
    end
  end

endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter
  import funnel_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic [1:0]    mode,
  output logic [W-1:0]  dout
);

  shmode_e       mode_e;
  logic [W-2:0]  upper_w;
  logic [W-1:0]  lower_w;
  logic [AW-1:0] offs_w;

  assign mode_e = shmode_e'(mode);

  funnel_ctrl #(.W(W), .AW(AW)) u_ctrl (
    .din   (din),
    .amt   (amt),
    .mode  (mode_e),
    .upper (upper_w),
    .lower (lower_w),
    .offs  (offs_w)
  );

  funnel_core #(.W(W), .AW(AW)) u_core (
    .upper (upper_w),
    .lower (lower_w),
    .offs  (offs_w),
    .win   (dout)
  );

  // Fill masks: positions the shifted data still occupies
  logic [W-1:0] keep_hi;
  logic [W-1:0] keep_lo;
  assign keep_hi = {W{1'b1}} >> amt;
  assign keep_lo = {W{1'b1}} << amt;

  always_comb begin
    if (mode_e == SH_LRIGHT) begin
      p_zero_fill_hi_r1: assert ((dout & ~keep_hi) == '0)
        else $error("logical right fill not zero");
    end
    if (mode_e == SH_ARIGHT && din[W-1]) begin
      p_sign_fill_r2: assert ((dout | keep_hi) == {W{1'b1}})
        else $error("arithmetic right fill not sign");
    end
    if (mode_e == SH_ROTR) begin
      p_ones_kept_r3: assert ($countones(dout) == $countones(din))
        else $error("rotate lost or gained bits");
    end
    if (mode_e == SH_LLEFT) begin
      p_zero_fill_lo_r4: assert ((dout & ~keep_lo) == '0)
        else $error("left shift fill not zero");
    end
    if (amt == '0) begin
      p_pass_through_r5: assert (dout == din)
        else $error("zero amount changed the word");
    end
  end

endmodule

// File: tb/funnel_shifter_test.sv
module funnel_shifter_test;

  localparam int W  = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic [W-1:0]  din = '0;
  logic [AW-1:0] amt = '0;
  logic [1:0]    mode = 2'b00;
  logic [W-1:0]  dout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  funnel_shifter #(.W(W), .AW(AW)) uut (
    .din  (din),
    .amt  (amt),
    .mode (mode),
    .dout (dout)
  );

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } item_t;

  item_t sb[$];

  // Reference model written with plain operators
  function automatic logic [W-1:0] ref_model(input logic [W-1:0] d, input int a, input int m);
    logic [2*W-1:0] dbl;
    case (m)
      0: return d >> a;
      1: return W'($signed(d) >>> a);
      2: begin
        dbl = {d, d} >> a;
        return dbl[W-1:0];
      end
      default: return d << a;
    endcase
  endfunction

  task automatic drive(input logic [W-1:0] d, input int a, input int m, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    din  = d;
    amt  = AW'(a);
    mode = 2'(m);
    it.exp = ref_model(d, a, m);
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compare at the falling edge after each drive
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (dout !== it.exp) begin
          errors++;
          $display("FAIL %s: din=%h amt=%0d mode=%0d actual=%h expected=%h",
                   it.tag, din, amt, mode, dout, it.exp);
        end
      end
    end
  end

  initial begin
    logic [W-1:0] pats[8];
    pats[0] = 32'h8000_0000;
    pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h0000_0001;
    pats[3] = 32'h7FFF_FFFF;
    pats[4] = 32'hA5C3_0F96;
    for (int i = 5; i < 8; i++) pats[i] = $urandom();

    // R6: combinational response, zero in gives zero out
    drive('0, 0, 0, "R6");
    drive('0, 17, 1, "R6");

    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 4; m++) begin
        for (int a = 0; a < W; a++) begin
          string tag;
          if (a == 0)      tag = "R5";
          else if (m == 0) tag = "R1";
          else if (m == 1) tag = "R2";
          else if (m == 2) tag = "R3";
          else             tag = "R4";
          drive(pats[p], a, m, tag);
        end
      end
    end

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule